// File: doc/BRIEF.md
# DVFS Transition Sequencer

This block moves a processor core from one performance level to another while the core keeps running. A fixed-frequency PLL clock feeds a set of divided clocks, and the sequencer chooses which divided clock drives the CPU and which supply-voltage code is requested from an external power management unit (PMU). By default there are three levels: the PLL runs at about 533 MHz, and the CPU clock is about 66, 133 or 266 MHz. The voltage codes cover the range from 1.0 V to 1.8 V.

The two steps are ordered so that the CPU clock never runs faster than the present supply allows. To go up, the block first asks for the higher voltage. It then waits until the PMU reports that the delivered voltage is adequate, and only after that selects the faster clock. To go down, it selects the slower clock first and then asks for the lower voltage. A clock change is break-before-make: the old divided clock is disabled for a fixed gap before the new one is enabled. Requests that arrive during a transition are held, the most recent one wins, and the held request is served once the current transition ends.

Top module: `dvfs_transition_seq`

## Requirements
- R1: After reset, clock source 0 is enabled (src_en = 1 in bit 0 only), div_sel = NLVL-1, vcode = VCODE_LO and busy = 0. With the defaults this is src_en=3'b001, div_sel=2, vcode=0.
- R2: At performance level L the block enables only src_en bit L and drives div_sel = NLVL-1-L, which selects a divide ratio of 2^(div_sel+1) from the PLL. It drives vcode = VCODE_LO + L*(VCODE_HI-VCODE_LO)/(NLVL-1). With the defaults the codes for levels 0, 1 and 2 are 0, 8 and 16.
- R3: On a raise, vcode moves to the new code first. The faster clock is enabled only after pmu_ready is seen high, and pmu_ready is sampled no earlier than the second clock edge after vcode changed.
- R4: On a lower, the slower clock is enabled first and vcode drops afterwards. busy stays high until pmu_ready confirms the lower voltage.
- R5: At most one src_en bit is high at any time. Between two different enabled sources, src_en is all zero for at least GAP_CYC cycles. div_sel changes only while src_en is all zero.
- R6: Whenever a source is enabled, vcode is at least the code that R2 gives for that source's level.
- R7: A request that arrives while busy is held and served after the current transition finishes. If several requests arrive, the last one wins.
- R8: A requested level of NLVL or more is treated as level NLVL-1.
- R9: A request for the level already in use starts no transition: busy stays 0 and the outputs do not change.
- R10: busy is high while a transition is in progress and low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe that carries a new level request |
| req_level | input | LW | Requested performance level (0 is the slowest) |
| pmu_ready | input | 1 | High when the delivered voltage meets the present vcode |
| div_sel | output | LW | Divider select; the ratio is 2^(div_sel+1) |
| src_en | output | NLVL | One-hot enable of the divided clock sources |
| vcode | output | VW | Supply voltage code sent to the PMU |
| busy | output | 1 | Transition in progress |
| cur_level | output | LW | Performance level currently in effect |

## Verification
The assertions take two things for granted about the inputs. First, the PMU drops pmu_ready by the first clock edge after it sees a new vcode, and raises it again only once that code is delivered. Second, req_valid is a single-cycle strobe. The bench PMU model meets the first assumption: it compares the vcode it sees against the previous one at every edge and holds ready low for a fixed delay after any change. It can also hold ready low on demand, to stretch the wait on a raise or on a lower. Requests are always single-cycle pulses driven at the falling edge, and a request made while busy changes only the held target, never the transition already running.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_VLOAD = 3'd1,
    ST_VSET  = 3'd2,
    ST_VWAIT = 3'd3,
    ST_GATE  = 3'd4
  } seq_state_e;

  // Limit a requested level to the highest level that exists.
  function automatic int clamp_level(int nlvl, int req);
    return (req > nlvl - 1) ? nlvl - 1 : req;
  endfunction

  // Divider select for a level: the fastest level uses select 0 (divide by 2).
  function automatic int div_of(int nlvl, int lvl);
    return nlvl - 1 - lvl;
  endfunction

  // Voltage code for a level, spread linearly between the low and high codes.
  function automatic int vcode_of(int lo, int hi, int nlvl, int lvl);
    if (nlvl < 2) return hi;
    return lo + (lvl * (hi - lo)) / (nlvl - 1);
  endfunction

endpackage

// File: rtl/dvfs_req_latch.sv
module dvfs_req_latch
  import dvfs_seq_pkg::*;
#(
  parameter int NLVL = 3,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [LW-1:0] req_level,
  output logic [LW-1:0] pend_level
);

  logic [LW-1:0] pend_q;

  // Holds the most recent request; a later strobe overwrites an earlier one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (req_valid) begin
      pend_q <= LW'(clamp_level(NLVL, int'(req_level)));
    end
  end

  assign pend_level = pend_q;

  // R8: the held target never names a level that does not exist
  a_r8_pend_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_q) <= NLVL - 1);

endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl
  import dvfs_seq_pkg::*;
#(
  parameter int NLVL    = 3,
  parameter int GAP_CYC = 2,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int GW = $clog2(GAP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] pend_level,
  input  logic          pmu_ready,
  output logic [LW-1:0] cmd_level,
  output logic          vload_evt,
  output logic          gate_evt,
  output logic          ungate_evt,
  output logic [LW-1:0] cur_level,
  output logic          busy
);

  seq_state_e    state_q, state_d;
  logic [LW-1:0] tgt_q;
  logic [LW-1:0] cur_q;
  logic          up_q;
  logic [GW-1:0] gap_q;

  // Named events used by the datapath modules and by the assertions.
  logic start_evt;
  logic start_up;
  logic volt_ok_evt;

  assign start_evt   = (state_q == ST_IDLE) && (pend_level != cur_q);
  assign start_up    = pend_level > cur_q;
  assign volt_ok_evt = (state_q == ST_VWAIT) && pmu_ready;

  assign cmd_level  = (state_q == ST_IDLE) ? pend_level : tgt_q;
  assign vload_evt  = (state_q == ST_VLOAD);
  assign gate_evt   = (start_evt && !start_up) || (volt_ok_evt && up_q);
  assign ungate_evt = (state_q == ST_GATE) && (gap_q == GW'(GAP_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_evt) state_d = start_up ? ST_VLOAD : ST_GATE;
      ST_VLOAD: state_d = ST_VSET;
      ST_VSET:  state_d = ST_VWAIT;
      ST_VWAIT: if (pmu_ready) state_d = up_q ? ST_GATE : ST_IDLE;
      ST_GATE:  if (ungate_evt) state_d = up_q ? ST_IDLE : ST_VLOAD;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      cur_q   <= '0;
      up_q    <= 1'b0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_evt) begin
        tgt_q <= pend_level;
        up_q  <= start_up;
      end
      if (gate_evt) begin
        gap_q <= '0;
      end else if (state_q == ST_GATE) begin
        gap_q <= gap_q + GW'(1);
      end
      if (ungate_evt) begin
        cur_q <= tgt_q;
      end
    end
  end

  assign cur_level = cur_q;
  assign busy      = (state_q != ST_IDLE);

  // R3: on a raise the faster clock waits for the PMU
  a_r3_raise_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VWAIT && up_q && !pmu_ready) |=> (state_q == ST_VWAIT));

  // R4: on a lower the voltage code is loaded only after the slower clock is on
  a_r4_clock_then_volt: assert property (@(posedge clk) disable iff (!rst_n)
    (vload_evt && !up_q) |-> $past(ungate_evt));

  // R4: the block stays busy until the lower voltage is confirmed
  a_r4_lower_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VWAIT && !up_q && !pmu_ready) |=> busy);

  // R7: a transition in flight keeps its target whatever new requests arrive
  a_r7_target_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(tgt_q));

  // R9: no transition starts when the held request equals the present level
  a_r9_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pend_level == cur_q) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dvfs_clk_select.sv
module dvfs_clk_select
  import dvfs_seq_pkg::*;
#(
  parameter int NLVL = 3,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate_evt,
  input  logic            ungate_evt,
  input  logic [LW-1:0]   cmd_level,
  output logic [LW-1:0]   div_sel,
  output logic [NLVL-1:0] src_en
);

  logic [LW-1:0]   div_q;
  logic [NLVL-1:0] en_q;

  // Break-before-make: the gate event clears every enable and moves the
  // divider select; the ungate event later enables only the new source.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= LW'(div_of(NLVL, 0));
      en_q  <= NLVL'(1);
    end else if (gate_evt) begin
      div_q <= LW'(div_of(NLVL, int'(cmd_level)));
      en_q  <= '0;
    end else if (ungate_evt) begin
      en_q  <= NLVL'(1) << cmd_level;
    end
  end

  assign div_sel = div_q;
  assign src_en  = en_q;

  // R5: never more than one source enabled
  a_r5_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_q));

  // R5: an enabled source is only ever followed by itself or by all-off
  a_r5_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != '0) |=> (en_q == '0 || $stable(en_q)));

  // R5: the divider select moves only while every source is off
  a_r5_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> (en_q == '0));

endmodule

// File: rtl/dvfs_volt_req.sv
module dvfs_volt_req
  import dvfs_seq_pkg::*;
#(
  parameter int NLVL     = 3,
  parameter int VW       = 5,
  parameter int VCODE_LO = 0,
  parameter int VCODE_HI = 16,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vload_evt,
  input  logic [LW-1:0] cmd_level,
  output logic [VW-1:0] vcode
);

  logic [VW-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= VW'(vcode_of(VCODE_LO, VCODE_HI, NLVL, 0));
    end else if (vload_evt) begin
      code_q <= VW'(vcode_of(VCODE_LO, VCODE_HI, NLVL, int'(cmd_level)));
    end
  end

  assign vcode = code_q;

  // R2: the requested code always stays inside the supply range
  a_r2_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(code_q) >= VCODE_LO && int'(code_q) <= VCODE_HI);

endmodule

// File: rtl/dvfs_transition_seq.sv
module dvfs_transition_seq
  import dvfs_seq_pkg::*;
#(
  parameter int NLVL     = 3,
  parameter int GAP_CYC  = 2,
  parameter int VW       = 5,
  parameter int VCODE_LO = 0,
  parameter int VCODE_HI = 16,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [LW-1:0]   req_level,
  input  logic            pmu_ready,
  output logic [LW-1:0]   div_sel,
  output logic [NLVL-1:0] src_en,
  output logic [VW-1:0]   vcode,
  output logic            busy,
  output logic [LW-1:0]   cur_level
);

  logic [LW-1:0] pend_level;
  logic [LW-1:0] cmd_level;
  logic          vload_evt;
  logic          gate_evt;
  logic          ungate_evt;

  dvfs_req_latch #(.NLVL(NLVL)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .pend_level (pend_level)
  );

  dvfs_seq_ctrl #(.NLVL(NLVL), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_level (pend_level),
    .pmu_ready  (pmu_ready),
    .cmd_level  (cmd_level),
    .vload_evt  (vload_evt),
    .gate_evt   (gate_evt),
    .ungate_evt (ungate_evt),
    .cur_level  (cur_level),
    .busy       (busy)
  );

  dvfs_clk_select #(.NLVL(NLVL)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_evt   (gate_evt),
    .ungate_evt (ungate_evt),
    .cmd_level  (cmd_level),
    .div_sel    (div_sel),
    .src_en     (src_en)
  );

  dvfs_volt_req #(
    .NLVL(NLVL), .VW(VW), .VCODE_LO(VCODE_LO), .VCODE_HI(VCODE_HI)
  ) u_volt (
    .clk       (clk),
    .rst_n     (rst_n),
    .vload_evt (vload_evt),
    .cmd_level (cmd_level),
    .vcode     (vcode)
  );

  // R6: an enabled clock never outruns the requested supply code
  a_r6_volt_covers_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en != '0) |->
      (int'(vcode) >= vcode_of(VCODE_LO, VCODE_HI, NLVL, int'(cur_level))));

  // R10: a level change takes effect only while a transition is in flight
  a_r10_busy_covers_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level) |-> $past(busy));

endmodule

// File: tb/dvfs_transition_seq_test.sv
module dvfs_transition_seq_test;

  localparam int NLVL    = 3;
  localparam int LW      = 2;
  localparam int VW      = 5;
  localparam int GAP     = 2;
  localparam int PMU_DLY = 4;
  localparam int NVEC    = 8;
  localparam int VREQ [NVEC] = '{2, 0, 1, 2, 1, 3, 0, 2};
  localparam int VEXP [NVEC] = '{2, 0, 1, 2, 1, 2, 0, 2};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            req_valid;
  logic [LW-1:0]   req_level;
  logic            pmu_ready;
  logic            pmu_hold;
  logic [LW-1:0]   div_sel;
  logic [NLVL-1:0] src_en;
  logic [VW-1:0]   vcode;
  logic            busy;
  logic [LW-1:0]   cur_level;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  dvfs_transition_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .pmu_ready(pmu_ready), .div_sel(div_sel), .src_en(src_en), .vcode(vcode),
    .busy(busy), .cur_level(cur_level)
  );

  // PMU model: ready falls for PMU_DLY cycles after the code it sees changes.
  logic [VW-1:0] seen_v;
  int pcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_v <= '0;
      pcnt   <= 0;
    end else begin
      seen_v <= vcode;
      if (vcode != seen_v) pcnt <= PMU_DLY;
      else if (pcnt != 0)  pcnt <= pcnt - 1;
    end
  end
  assign pmu_ready = (pcnt == 0) && !pmu_hold;

  function automatic int exp_code(int l);
    return l * 8;
  endfunction

  function automatic int lvl_of(logic [NLVL-1:0] v);
    int r = 0;
    for (int i = 0; i < NLVL; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Continuous monitor for ordering rules.
  int mon_bad = 0;
  int zero_run;
  logic [NLVL-1:0] last_on, prev_src;
  logic [LW-1:0]   prev_div;
  bit saw_low = 0;

  task automatic mon_fail(string tag, int act, int exp);
    mon_bad++;
    $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      zero_run = 0;
      last_on  = '0;
      prev_src = '0;
      prev_div = LW'(NLVL - 1);
    end else begin
      if ($countones(src_en) > 1) mon_fail("R5 onehot", $countones(src_en), 1);
      if (src_en == '0) begin
        zero_run++;
      end else begin
        if (last_on != '0 && src_en != last_on && zero_run < GAP)
          mon_fail("R5 gap", zero_run, GAP);
        if (prev_src == '0 && last_on != '0 && lvl_of(src_en) > lvl_of(last_on) && !pmu_ready)
          mon_fail("R3 ready at raise", 0, 1);
        last_on  = src_en;
        zero_run = 0;
      end
      if (div_sel != prev_div && src_en != '0)
        mon_fail("R5 div while enabled", int'(src_en), 0);
      if (src_en != '0 && int'(vcode) < exp_code(lvl_of(src_en)))
        mon_fail("R6 vcode below clock", int'(vcode), exp_code(lvl_of(src_en)));
      if (src_en == 3'b001) saw_low = 1;
      prev_div = div_sel;
      prev_src = src_en;
    end
  end

  task automatic request(int l);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = LW'(l);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic chk_level(string tag, int l);
    chk({tag, " src_en"}, int'(src_en), 1 << l);
    chk({tag, " div_sel"}, int'(div_sel), NLVL - 1 - l);
    chk({tag, " vcode"}, int'(vcode), exp_code(l));
    chk({tag, " cur_level"}, int'(cur_level), l);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_level = '0; pmu_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_level("R1 reset", 0);
    chk("R1 busy", int'(busy), 0);

    // Table walk: R2 mapping across raises and lowers, R8 clamp at entry 5.
    for (int i = 0; i < NVEC; i++) begin
      request(VREQ[i]);
      wait_idle();
      chk_level((VREQ[i] >= NLVL) ? "R8 clamp" : "R2 level", VEXP[i]);
      chk("R10 idle busy", int'(busy), 0);
    end

    // R9: a request for the present level (2) does nothing.
    request(2);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 busy", int'(busy), 0);
    end
    chk_level("R9 unchanged", 2);

    // R4: lower 2 -> 0, clock drops before the code.
    request(0);
    for (int k = 0; k < 60 && src_en != 3'b001; k++) @(negedge clk);
    chk("R4 slow clock on", int'(src_en), 1);
    chk("R4 code still high", int'(vcode), 16);
    pmu_hold = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4 busy while unconfirmed", int'(busy), 1);
    chk("R4 code lowered", int'(vcode), 0);
    pmu_hold = 1'b0;
    wait_idle();
    chk_level("R4 done", 0);

    // R3: raise 0 -> 2 with the PMU stalled.
    pmu_hold = 1'b1;
    request(2);
    repeat (20) @(negedge clk);
    chk("R3 code raised first", int'(vcode), 16);
    chk("R3 clock held", int'(src_en), 1);
    chk("R10 busy in transition", int'(busy), 1);
    pmu_hold = 1'b0;
    wait_idle();
    chk_level("R3 done", 2);

    // R7: requests while busy are held; the last one wins.
    saw_low = 0;
    request(0);
    repeat (2) @(negedge clk);
    chk("R7 busy at second request", int'(busy), 1);
    request(1);
    request(2);
    wait_idle();
    chk("R7 first target reached", int'(saw_low), 1);
    chk_level("R7 last wins", 2);

    // R1: reset in the middle of operation.
    @(posedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk_level("R1 mid reset", 0);
    chk("R1 mid reset busy", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R3 R5 R6 monitor", mon_bad, 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule